// File: doc/BRIEF.md
# Modulo-16 Vector-Matrix Cipher Datapath

This block carries out the arithmetic core of a linear block cipher. It takes a row vector of three 4-bit elements and multiplies it by a 3x3 key matrix of 4-bit elements. Every product and every sum wraps modulo 16. The result is a three-element vector that is either the encrypted or the decrypted form of the input.

Two complete key matrices arrive on wide inputs: one for encryption and one for decryption. The block does not capture them. They are expected to stay steady while data flows through. A select bit, sampled on the same edge as the data, chooses which of the two keys is applied. The input vector is registered on one rising edge and the result is registered on the next. A new vector may therefore be accepted on every cycle, and each result appears two edges after its input.

Top module: `vecmat_cipher`

## Requirements
- R1: Each data and key element is 4 bits wide. Vector element i (i = 1..3) occupies bits [4(i-1)+3 : 4(i-1)]. Key element in row r, column c (r, c = 1..3) occupies bits [4(3(r-1)+(c-1))+3 : 4(3(r-1)+(c-1))].
- R2: Output element c equals p1·k1c + p2·k2c + p3·k3c modulo 16, where p is the registered input vector and k is the selected key.
- R3: Products and sums keep their four least significant bits and drop the upper bits. For example, 5·7 gives 3, and 15·15 summed over three rows gives 3.
- R4: The input vector and the select are sampled only at the rising clock edge. Values driven between edges have no effect on the result.
- R5: The select is registered on the same edge as the vector. A registered 1 applies the encryption key and a registered 0 applies the decryption key.
- R6: The keys are not registered inside the block. The result is formed from the key values present at the output edge, one cycle after the vector was captured.
- R7: A result appears on the second rising edge after its vector is presented. Vectors may be presented on consecutive cycles, and each result follows in the same order.
- R8: While the active-low reset is asserted, the output reads zero. A zero input vector yields a zero output under any key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_in | input | 12 | Input vector, three 4-bit elements |
| enc_sel | input | 1 | 1 selects the encryption key, 0 the decryption key |
| enc_key | input | 36 | Encryption key matrix, nine 4-bit elements |
| dec_key | input | 36 | Decryption key matrix, nine 4-bit elements |
| vec_out | output | 12 | Registered result vector, three 4-bit elements |

## Verification
The internal state consists only of the captured vector, the captured select and the result register. A wrong value in any of them reaches the output no later than the next edge, so every fault shows up within two cycles of the stimulus that caused it. A select captured with the wrong polarity or on the wrong edge shows up as a result computed with the other key. A key that is registered by mistake shows up only when the key changes while a vector is in flight. A dropped high or low bit is exposed by operands whose full products exceed 15.

// File: rtl/vecmat_cipher.sv
module vecmat_cipher #(
  parameter int W = 4,
  parameter int N = 3,
  localparam int VW = N * W,
  localparam int KW = N * N * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vec_in,
  input  logic          enc_sel,
  input  logic [KW-1:0] enc_key,
  input  logic [KW-1:0] dec_key,
  output logic [VW-1:0] vec_out
);

  logic [VW-1:0] vec_q;
  logic          sel_q;
  logic [KW-1:0] key_act;
  logic [VW-1:0] acc;

  assign key_act = sel_q ? enc_key : dec_key;

  for (genvar c = 0; c < N; c++) begin : g_col
    logic [W-1:0] term [N];
    logic [W-1:0] sum;
    for (genvar r = 0; r < N; r++) begin : g_row
      assign term[r] = vec_q[r*W +: W] * key_act[(r*N+c)*W +: W];
    end
    always_comb begin
      sum = '0;
      for (int r = 0; r < N; r++) sum = sum + term[r];
    end
    assign acc[c*W +: W] = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      sel_q   <= 1'b0;
      vec_out <= '0;
    end else begin
      vec_q   <= vec_in;
      sel_q   <= enc_sel;
      vec_out <= acc;
    end
  end

  function automatic logic is_unit(input logic [KW-1:0] k);
    logic ok;
    ok = 1'b1;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (k[(r*N+c)*W +: W] != ((r == c) ? W'(1) : W'(0))) ok = 1'b0;
    return ok;
  endfunction

  assert_zero_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_q == '0) |=> (vec_out == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(vec_q) && $stable(sel_q) && $stable(enc_key) && $stable(dec_key))
      |=> $stable(vec_out));

  assert_enc_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && is_unit(enc_key)) |=> (vec_out == $past(vec_q)));

  assert_dec_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && is_unit(dec_key)) |=> (vec_out == $past(vec_q)));

endmodule

// File: tb/test_vecmat_cipher.sv
module test_vecmat_cipher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] vec_in = '0;
  logic        enc_sel = 1'b0;
  logic [35:0] enc_key = '0;
  logic [35:0] dec_key = '0;
  logic [11:0] vec_out;

  vecmat_cipher i_vecmat_cipher (.*);

  always #5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic drv_valid = 1'b0;
  logic [1:0] vpipe;
  logic [11:0] exp_q[$];
  string tag_q[$];

  function automatic logic [11:0] model(input logic [11:0] v, input logic [35:0] k);
    logic [11:0] r;
    for (int c = 0; c < 3; c++) begin
      int s;
      s = 0;
      for (int i = 0; i < 3; i++)
        s += int'(v[i*4 +: 4]) * int'(k[(i*3+c)*4 +: 4]);
      r[c*4 +: 4] = 4'(s % 16);
    end
    return r;
  endfunction

  function automatic logic [35:0] one_elem(input int r, input int c, input logic [3:0] val);
    logic [35:0] k;
    k = '0;
    k[((r-1)*3+(c-1))*4 +: 4] = val;
    return k;
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] v, input logic s, input string tag);
    @(negedge clk);
    vec_in = v;
    enc_sel = s;
    drv_valid = 1'b1;
    exp_q.push_back(model(v, s ? enc_key : dec_key));
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    vec_in = 12'($urandom);
    enc_sel = ~s;
  endtask

  task automatic drain();
    @(negedge clk);
    drv_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vpipe <= '0;
    else vpipe <= {vpipe[0], drv_valid};

  always @(negedge clk) begin
    if (rst_n && vpipe[1]) begin
      if (exp_q.size() == 0) check("R7 unexpected output", vec_out, 12'hxxx);
      else check(tag_q.pop_front(), vec_out, exp_q.pop_front());
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    enc_key = {$urandom, 4'($urandom)};
    dec_key = {$urandom, 4'($urandom)};
    vec_in = 12'hABC;
    enc_sel = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset output", vec_out, '0);
    rst_n = 1'b1;

    send(12'h000, 1'b1, "R8 zero vector enc");
    send(12'h000, 1'b0, "R8 zero vector dec");
    drain();

    enc_key = one_elem(2, 3, 4'd1);
    send(12'h090, 1'b1, "R1 element placement row2 col3");
    send(12'h00F, 1'b1, "R1 element row1 unused");
    drain();

    enc_key = one_elem(1, 1, 4'd7);
    send(12'h005, 1'b1, "R3 wrap 5x7");
    drain();
    enc_key = '1;
    send(12'hFFF, 1'b1, "R3 all ones wrap");
    send(12'h8F1, 1'b1, "R3 mixed wrap");
    drain();

    enc_key = 36'h123456789;
    dec_key = 36'hFEDCBA987;
    send(12'h321, 1'b1, "R5 select encrypt");
    send(12'h321, 1'b0, "R5 select decrypt");
    send(12'h7A4, 1'b0, "R5 alternate dec");
    send(12'h7A4, 1'b1, "R5 alternate enc");
    drain();

    for (int i = 0; i < 40; i++)
      send(12'($urandom), 1'($urandom), "R2 R7 random stream");
    drain();

    enc_key = {$urandom, 4'($urandom)};
    dec_key = {$urandom, 4'($urandom)};
    for (int i = 0; i < 20; i++)
      send(12'($urandom), 1'($urandom), "R2 R4 second key set");
    drain();

    @(negedge clk);
    vec_in = 12'h5E3;
    enc_sel = 1'b1;
    @(posedge clk);
    #1;
    vec_in = 12'h000;
    enc_sel = 1'b0;
    @(negedge clk);
    enc_key = 36'h9A2C4E61B;
    @(negedge clk);
    check("R6 key taken at output edge", vec_out, model(12'h5E3, 36'h9A2C4E61B));
    repeat (2) @(negedge clk);

    if (exp_q.size() != 0) check("R7 results missing", 12'(exp_q.size()), 12'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule